// File: doc/BRIEF.md
# Stochastic Delay Queue Device

This block models a single N-input logic gate whose inputs reach the gate only after a random number of cycles. On every clock edge each input bit is captured together with a delay drawn from a per-input programmable discrete distribution. The pair waits in a small per-input queue, and the remaining delay of every entry counts down by one each cycle. When an entry reaches zero, its value is moved into a hidden register for that input. The output `y` is a programmable Boolean function of the hidden registers, given as a truth table.

The queue is not a first-in first-out buffer. A new sample discards every waiting entry of the same input whose remaining delay is not below the new sample's delay, so a fast sample overtakes and erases slower ones. Because of this, the delays in a queue are always strictly ordered, and a queue with DMAX+1 slots never overflows. The block is meant for studying how often a timing-unreliable gate still gives the correct answer. Such a study drives it from periodic random sources and compares `y` with the ideal function.

Top module: `stoch_delay_dev`

## Requirements
- R1: While `rst_n` is low, all hidden bits are 0 and every queue is empty. `y` then equals `fn_tbl[0]`, and no sample taken before reset ever reaches a hidden bit.
- R2: The delay for input i is the number of table entries k (0..NBIN-1) whose threshold, at `dly_tbl[(i*NBIN+k)*THR_W +: THR_W]`, is strictly less than that input's random byte. The random byte comes from a per-input maximal-length LFSR and is never zero. A threshold of 0 therefore always counts, and a threshold of 255 never counts.
- R3: If a sample is captured at edge t with delay d and is not discarded, its value appears on `hidden[i]` right after edge t+d+1. A delay of 0 appears one cycle after capture.
- R4: Capturing a sample with delay d removes every pending entry of that input whose remaining delay, after this edge's count-down, is greater than or equal to d. Removed entries never reach the hidden bit.
- R5: Each pending entry that is not removed and not latched has its remaining delay lowered by exactly one per cycle. Older entries with smaller remaining delay survive a newer sample with a larger delay.
- R6: At most one entry per queue reaches zero in any cycle. A hidden bit changes only at an edge where an entry of its queue is at zero.
- R7: `y` equals `fn_tbl[idx]`, where idx is formed from the hidden bits with `hidden[0]` as the least significant bit. `y` holds while the hidden bits and `fn_tbl` are unchanged.
- R8: Every captured sample finds a free slot in its queue of DMAX+1 slots.
- R9: A threshold count above DMAX is clamped to a delay of DMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_IN | Source bits, one per device input |
| dly_tbl | input | N_IN*NBIN*THR_W | Per-input cumulative threshold tables |
| fn_tbl | input | 2**N_IN | Truth table of the device function |
| hidden | output | N_IN | Latched (hidden) input values seen by the function |
| y | output | 1 | Device output |

## Verification
A queue entry that keeps a wrong remaining delay, or that should have been removed, shows up on `hidden` as a value that is late, early, or from a discarded sample. This happens no later than DMAX+1 cycles after the capture in question, and it then spreads through the truth table to `y` in the same cycle. The delay tables are driven with thresholds of only 0 and 255, which fixes every delay exactly. A per-cycle reference of the queue rules can then predict every hidden bit and `y` on every cycle, through sweeps of fixed delays, abrupt delay changes, clamped delays and reset in mid-stream.

// File: rtl/sdq_pkg.sv
`timescale 1ns/1ps
package sdq_pkg;

   // Galois feedback mask of a maximal-length LFSR for the supported widths
   function automatic logic [31:0] lfsr_taps(input int w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         default: return 32'h0;
      endcase
   endfunction

   // Distinct, never-zero seed for each device input
   function automatic logic [31:0] lfsr_seed(input int idx, input int w);
      logic [31:0] mask;
      mask = (32'h1 << w) - 32'h1;
      return ((32'h5A + 32'd29 * 32'(idx)) & mask) | 32'h1;
   endfunction

endpackage

// File: rtl/sdq_lfsr.sv
`timescale 1ns/1ps
module sdq_lfsr #(
   parameter int          W    = 8,
   parameter logic [31:0] SEED = 32'h5A
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] rnd
);
   import sdq_pkg::*;

   localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));
   localparam logic [W-1:0] INIT = W'(SEED);

   logic [W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st <= INIT;
      else if (st[0]) st <= (st >> 1) ^ TAPS;
      else            st <= st >> 1;
   end

   assign rnd = st;
endmodule

// File: rtl/sdq_pick.sv
`timescale 1ns/1ps
module sdq_pick #(
   parameter int NBIN  = 16,
   parameter int THR_W = 8,
   parameter int DMAX  = 10,
   parameter int DW    = 4
) (
   input  logic [NBIN*THR_W-1:0] thr,
   input  logic [THR_W-1:0]      rnd,
   output logic [DW-1:0]         dly
);
   localparam int CW = $clog2(NBIN + 1);

   logic [CW-1:0] cnt;

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NBIN; k++)
         if (rnd > thr[k*THR_W +: THR_W]) cnt = cnt + 1'b1;
   end

   generate
      if (NBIN > DMAX) begin : g_clamp
         assign dly = (cnt > CW'(DMAX)) ? DW'(DMAX) : DW'(cnt);
      end else begin : g_direct
         assign dly = DW'(cnt);
      end
   endgenerate
endmodule

// File: rtl/sdq_queue.sv
`timescale 1ns/1ps
module sdq_queue #(
   parameter int DMAX = 10,
   parameter int DW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic [DW-1:0]     dnew,
   output logic              hid,
   output logic [DMAX:0]     zmask,
   output logic              ins_ok
);
   localparam int SLOTS = DMAX + 1;
   localparam int IW    = $clog2(SLOTS);

   logic [SLOTS-1:0] vld, val, keep;
   logic [DW-1:0]    rem [SLOTS];
   logic [IW-1:0]    ins_idx;
   logic             found;

   // zero-delay entries leave now; the rest age and are pruned against dnew
   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         zmask[s] = vld[s] && (rem[s] == '0);
         keep[s]  = vld[s] && (rem[s] != '0) && ((rem[s] - 1'b1) < dnew);
      end
   end

   always_comb begin
      found   = 1'b0;
      ins_idx = '0;
      for (int s = SLOTS - 1; s >= 0; s--)
         if (!keep[s]) begin
            found   = 1'b1;
            ins_idx = IW'(s);
         end
   end

   assign ins_ok = found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         val <= '0;
         hid <= 1'b0;
         for (int s = 0; s < SLOTS; s++) rem[s] <= '0;
      end else begin
         if (|zmask) hid <= |(zmask & val);
         for (int s = 0; s < SLOTS; s++) begin
            if (found && (ins_idx == IW'(s))) begin
               vld[s] <= 1'b1;
               val[s] <= din;
               rem[s] <= dnew;
            end else begin
               vld[s] <= keep[s];
               if (keep[s]) rem[s] <= rem[s] - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/stoch_delay_dev.sv
`timescale 1ns/1ps
module stoch_delay_dev #(
   parameter int N_IN  = 2,
   parameter int DMAX  = 10,
   parameter int NBIN  = 16,
   parameter int THR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_IN-1:0]            src_in,
   input  logic [N_IN*NBIN*THR_W-1:0] dly_tbl,
   input  logic [(1<<N_IN)-1:0]       fn_tbl,
   output logic [N_IN-1:0]            hidden,
   output logic                       y
);
   import sdq_pkg::*;

   localparam int SLOTS = DMAX + 1;
   localparam int DW    = $clog2(DMAX + 1);
   localparam int TBLW  = NBIN * THR_W;

   generate
      if (N_IN < 1 || N_IN > 4) begin : g_bad_n
         $error("stoch_delay_dev: N_IN must be 1..4");
      end
      if (DMAX < 1 || DMAX > 15) begin : g_bad_dmax
         $error("stoch_delay_dev: DMAX must be 1..15");
      end
      if (THR_W != 8 && THR_W != 16) begin : g_bad_w
         $error("stoch_delay_dev: THR_W must be 8 or 16");
      end
   endgenerate

   logic [N_IN*SLOTS-1:0] zmask_all;
   logic [N_IN-1:0]       ins_ok;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         logic [THR_W-1:0] rnd;
         logic [DW-1:0]    dly;

         sdq_lfsr #(.W(THR_W), .SEED(lfsr_seed(i, THR_W))) i_lfsr (
            .clk(clk), .rst_n(rst_n), .rnd(rnd));

         sdq_pick #(.NBIN(NBIN), .THR_W(THR_W), .DMAX(DMAX), .DW(DW)) i_pick (
            .thr(dly_tbl[i*TBLW +: TBLW]), .rnd(rnd), .dly(dly));

         sdq_queue #(.DMAX(DMAX), .DW(DW)) i_q (
            .clk(clk), .rst_n(rst_n), .din(src_in[i]), .dnew(dly),
            .hid(hidden[i]), .zmask(zmask_all[i*SLOTS +: SLOTS]),
            .ins_ok(ins_ok[i]));
      end
   endgenerate

   assign y = fn_tbl[hidden];
endmodule

// File: rtl/sdq_chk.sv
`timescale 1ns/1ps
module sdq_chk #(
   parameter int N_IN  = 2,
   parameter int SLOTS = 11
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_IN-1:0]         hidden,
   input logic                    y,
   input logic [(1<<N_IN)-1:0]    fn_tbl,
   input logic [N_IN*SLOTS-1:0]   zmask_all,
   input logic [N_IN-1:0]         ins_ok
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (hidden == '0));

   // R7
   y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(hidden) && $stable(fn_tbl)) |-> $stable(y));

   // R8
   slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_ok == '1);

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_q
         // R6
         one_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(zmask_all[i*SLOTS +: SLOTS]) <= 1);
         // R6
         hid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(hidden[i]) |-> $past(|zmask_all[i*SLOTS +: SLOTS]));
      end
   endgenerate
endmodule

bind stoch_delay_dev sdq_chk #(.N_IN(N_IN), .SLOTS(SLOTS)) i_sdq_chk (
   .clk(clk), .rst_n(rst_n), .hidden(hidden), .y(y), .fn_tbl(fn_tbl),
   .zmask_all(zmask_all), .ins_ok(ins_ok));

// File: tb/test_stoch_delay_dev.sv
`timescale 1ns/1ps
module test_stoch_delay_dev;
   localparam int N_IN  = 2;
   localparam int DMAX  = 10;
   localparam int NBIN  = 16;
   localparam int THR_W = 8;
   localparam int SLOTS = DMAX + 1;
   localparam int TBLW  = NBIN * THR_W;

   logic                       clk = 1'b0;
   logic                       rst_n = 1'b0;
   logic [N_IN-1:0]            src_in = '0;
   logic [N_IN*TBLW-1:0]       dly_tbl = '1;
   logic [(1<<N_IN)-1:0]       fn_tbl = 4'b1000;
   logic [N_IN-1:0]            hidden;
   logic                       y;

   int n_chk = 0;
   int n_err = 0;

   // reference state of the queues
   bit mvld [N_IN][SLOTS];
   bit mv   [N_IN][SLOTS];
   int mr   [N_IN][SLOTS];
   bit mh   [N_IN];

   always #4 clk = ~clk;

   stoch_delay_dev #(.N_IN(N_IN), .DMAX(DMAX), .NBIN(NBIN), .THR_W(THR_W))
      i_stoch_delay_dev (.clk(clk), .rst_n(rst_n), .src_in(src_in),
                         .dly_tbl(dly_tbl), .fn_tbl(fn_tbl),
                         .hidden(hidden), .y(y));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < N_IN; i++) begin
         mh[i] = 1'b0;
         for (int s = 0; s < SLOTS; s++) begin
            mvld[i][s] = 1'b0; mv[i][s] = 1'b0; mr[i][s] = 0;
         end
      end
   endtask

   // R2: thresholds 0 for entries below d, 255 above, so the count is exactly d
   function automatic logic [TBLW-1:0] tbl_for(input int d);
      logic [TBLW-1:0] t;
      for (int k = 0; k < NBIN; k++)
         t[k*THR_W +: THR_W] = (k < d) ? 8'h00 : 8'hFF;
      return t;
   endfunction

   task automatic model_step(input logic [N_IN-1:0] x, input int dreq [N_IN]);
      for (int i = 0; i < N_IN; i++) begin
         int d;
         bit placed;
         d = (dreq[i] > DMAX) ? DMAX : dreq[i];          // R9
         for (int s = 0; s < SLOTS; s++) begin
            if (mvld[i][s] && mr[i][s] == 0) begin mh[i] = mv[i][s]; mvld[i][s] = 1'b0; end
            else if (mvld[i][s]) mr[i][s]--;
         end
         for (int s = 0; s < SLOTS; s++)
            if (mvld[i][s] && mr[i][s] >= d) mvld[i][s] = 1'b0;   // R4
         placed = 1'b0;
         for (int s = 0; s < SLOTS; s++)
            if (!placed && !mvld[i][s]) begin
               mvld[i][s] = 1'b1; mv[i][s] = x[i]; mr[i][s] = d; placed = 1'b1;
            end
         if (!placed) chk("R8 model slot", 0, 1);
      end
   endtask

   // one cycle: drive at negedge, reference advances at the edge, compare at next negedge
   task automatic cyc(input logic [N_IN-1:0] x, input int d0, input int d1, input string tag);
      int dreq [N_IN];
      dreq[0] = d0; dreq[1] = d1;
      src_in = x;
      dly_tbl = {tbl_for(d1), tbl_for(d0)};
      @(posedge clk);
      model_step(x, dreq);
      @(negedge clk);
      chk({tag, " hidden0"}, int'(hidden[0]), int'(mh[0]));
      chk({tag, " hidden1"}, int'(hidden[1]), int'(mh[1]));
      chk("R7 y", int'(y), int'(fn_tbl[{mh[1], mh[0]}]));
   endtask

   initial begin
      #(8 * 200000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [3:0] fns [4];
      fns[0] = 4'b1000; fns[1] = 4'b1110; fns[2] = 4'b0110; fns[3] = 4'b1001;
      model_clear();

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 hidden", int'(hidden), 0);
      chk("R1 y and", int'(y), 0);
      fn_tbl = 4'b0001;
      #1;
      chk("R1 y index0", int'(y), 1);
      fn_tbl = 4'b1000;
      rst_n = 1'b1;

      // R3: sweep of fixed delays 0..DMAX on both inputs
      for (int d0 = 0; d0 <= DMAX; d0++) begin
         fn_tbl = fns[d0 % 4];
         for (int c = 0; c < 30; c++)
            cyc(N_IN'($urandom_range(3)), d0, DMAX - d0, "R3");
      end

      // R4/R5: abrupt delay changes in both directions, with zero delays
      for (int c = 0; c < 150; c++) begin
         int a, b;
         a = ((c / 9) % 2) ? 1 : 7;
         b = ((c / 5) % 2) ? 9 : 2;
         if (c % 13 == 0) a = 0;
         fn_tbl = fns[(c / 37) % 4];
         cyc(N_IN'($urandom_range(3)), a, b, "R4/R5");
      end

      // R9: all thresholds 0 gives a count of 16, clamped to DMAX
      fn_tbl = 4'b0110;
      for (int c = 0; c < 40; c++)
         cyc(N_IN'($urandom_range(3)), 16, 16, "R9");

      // R4/R5/R6/R8: random delay every cycle, some above DMAX
      for (int c = 0; c < 400; c++) begin
         fn_tbl = fns[(c / 50) % 4];
         cyc(N_IN'($urandom_range(3)), $urandom_range(12), $urandom_range(12), "R4/R6");
      end

      // R1: reset in mid-stream discards pending samples
      src_in = 2'b11;
      fn_tbl = 4'b0001;
      @(negedge clk);
      rst_n = 1'b0;
      model_clear();
      #1;
      chk("R1 mid hidden", int'(hidden), 0);
      chk("R1 mid y", int'(y), 1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 30; c++)
         cyc(2'b00, 8, 5, "R1 after");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule